// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a host and one four-bank SDRAM device. It brings the memory up after reset, turns each host read or write request into a bank activate followed by a column access with auto-precharge, and slots periodic auto refresh in between requests. Only one access is in flight at a time. Every row is closed by the column command itself, so no bank is left open between requests.

The host holds `req_valid`, `req_write` and `req_addr` steady until `req_ready` is high for one cycle. That cycle is the acknowledge, and the activate goes out on the next clock. All memory pins are registered. Every delay is a parameter counted in clock cycles, and the sequencer always issues the next command at the first cycle its delays allow. Burst length is one; the mode word written at power-up is the parameter `MODE_WORD`.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `mem_cke` is 0, all four strobes (`mem_cs_n`, `mem_ras_n`, `mem_cas_n`, `mem_we_n`) are 1, and `req_ready` is 0.
- R2: After reset is released, the first command is a precharge with `mem_addr[10]`=1 (all banks), issued on the (T_INIT+1)-th rising edge. Two auto refreshes follow it, then a mode register set that carries `MODE_WORD` on `mem_addr` and 0 on `mem_ba`. Strobe codes as {cs_n,ras_n,cas_n,we_n}: precharge 0010, auto refresh 0001, mode set 0000.
- R3: Inside the power-up sequence, the first refresh comes exactly T_RP cycles after the precharge, the second exactly T_RFC after the first, and the mode set exactly T_RFC after the second. No command follows any refresh sooner than T_RFC cycles, or follows the mode set sooner than T_MRD cycles.
- R4: `req_ready` is high in exactly one cycle per request. In the next cycle an activate (0011) is on the pins, with `mem_ba` = `req_addr[22:21]` and `mem_addr` = `req_addr[20:9]`.
- R5: The column command comes exactly T_RCD cycles after its activate, with the same bank. `mem_addr[8:0]` = `req_addr[8:0]`, `mem_addr[10]`=1 and the other address bits are 0.
- R6: A request with `req_write`=1 produces a write (0100). A request with `req_write`=0 produces a read (0101).
- R7: After a write, the next activate or refresh comes exactly max(T_RC−T_RCD, T_DAL) cycles later. After a read, it comes exactly max(T_RC−T_RCD, T_RP+1) cycles later.
- R8: A refresh falls due every T_REFI cycles. While the bank is idle, consecutive refreshes are exactly T_REFI apart. A refresh that falls due in the same cycle as a waiting request goes out first, and the activate follows T_RFC later. A refresh that falls due during an access waits for that access's recovery from R7.
- R9: From the first edge after reset, `mem_cke` stays 1, `mem_cs_n` stays 0, and every cycle carries either one of the commands above or a no-op (0111).
- R10: `req_ready` stays 0 until T_MRD−1 cycles after the mode register set, whatever the state of `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank[1:0], row[11:0], column[8:0]} |
| req_ready | output | 1 | Acknowledge, one cycle per request |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 12 | Row, column or mode word; bit 10 is auto-precharge / all banks |
| mem_ba | output | 2 | Bank select |

## Verification
A refresh that falls due and a host request that is waiting can meet in the same idle cycle. The bench learns the refresh phase by timing two idle refreshes. It then raises a read request exactly one cycle before the next refresh is due, and expects the refresh on the pins first, no acknowledge in that cycle, and the activate T_RFC cycles later. A second case raises a write one cycle earlier than that. The write must win, and the refresh must then land exactly on the write recovery boundary.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10,
  parameter int T_INIT = 20000,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_RC   = 7,
  parameter int T_RFC  = 7,
  parameter int T_MRD  = 2,
  parameter int T_DAL  = 4,
  parameter int T_REFI = 1560,
  parameter logic [ROW_W-1:0] MODE_WORD = 12'h020
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [BA_W+ROW_W+COL_W-1:0]  req_addr,
  output logic                         req_ready,
  output logic                         mem_cke,
  output logic                         mem_cs_n,
  output logic                         mem_ras_n,
  output logic                         mem_cas_n,
  output logic                         mem_we_n,
  output logic [ROW_W-1:0]             mem_addr,
  output logic [BA_W-1:0]              mem_ba
);
  localparam int ADDR_W = BA_W + ROW_W + COL_W;
  localparam int RC_TAIL = T_RC - T_RCD;
  localparam int WR_GAP = (RC_TAIL > T_DAL) ? RC_TAIL : T_DAL;
  localparam int RD_GAP = (RC_TAIL > T_RP + 1) ? RC_TAIL : T_RP + 1;
  localparam int CNT_W = $clog2(T_INIT + T_RC + T_DAL + T_RFC + T_RP + T_MRD + T_RCD + 1);
  localparam int REF_W = $clog2(T_REFI + 1);

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                         C_NOP = 4'b0111;

  typedef enum logic [2:0] {S_PRE, S_REF1, S_REF2, S_MRS, S_IDLE, S_RW} state_t;

  state_t            state, nxt;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_pend, init_done, init_set, take, ref_clr;
  logic              wr_l;
  logic [BA_W-1:0]   ba_l, ba_d;
  logic [COL_W-1:0]  col_l;
  logic [ROW_W-1:0]  a_d;
  logic [3:0]        cmd_q, cmd_d;

  wire [BA_W-1:0]  req_bank = req_addr[ADDR_W-1 -: BA_W];
  wire [ROW_W-1:0] req_row  = req_addr[COL_W +: ROW_W];
  wire [COL_W-1:0] req_col  = req_addr[COL_W-1:0];
  wire             slot     = (cnt == '0);

  assign req_ready = (state == S_IDLE) && slot && !ref_pend && req_valid;
  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;

  always_comb begin
    nxt      = state;
    cnt_d    = slot ? '0 : cnt - 1'b1;
    cmd_d    = C_NOP;
    a_d      = '0;
    ba_d     = '0;
    take     = 1'b0;
    ref_clr  = 1'b0;
    init_set = 1'b0;
    if (slot) begin
      case (state)
        S_PRE: begin
          cmd_d = C_PRE; a_d[AP_BIT] = 1'b1;
          cnt_d = CNT_W'(T_RP - 1); nxt = S_REF1;
        end
        S_REF1: begin
          cmd_d = C_REF; cnt_d = CNT_W'(T_RFC - 1); nxt = S_REF2;
        end
        S_REF2: begin
          cmd_d = C_REF; cnt_d = CNT_W'(T_RFC - 1); nxt = S_MRS;
        end
        S_MRS: begin
          cmd_d = C_MRS; a_d = MODE_WORD;
          cnt_d = CNT_W'(T_MRD - 1); nxt = S_IDLE; init_set = 1'b1;
        end
        S_IDLE: begin
          if (ref_pend) begin
            cmd_d = C_REF; cnt_d = CNT_W'(T_RFC - 1); ref_clr = 1'b1;
          end else if (req_valid) begin
            cmd_d = C_ACT; ba_d = req_bank; a_d = req_row;
            cnt_d = CNT_W'(T_RCD - 1); nxt = S_RW; take = 1'b1;
          end
        end
        S_RW: begin
          cmd_d = wr_l ? C_WR : C_RD;
          ba_d = ba_l;
          a_d[COL_W-1:0] = col_l;
          a_d[AP_BIT] = 1'b1;
          cnt_d = wr_l ? CNT_W'(WR_GAP - 1) : CNT_W'(RD_GAP - 1);
          nxt = S_IDLE;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PRE;
      cnt       <= CNT_W'(T_INIT);
      cmd_q     <= 4'b1111;
      mem_addr  <= '0;
      mem_ba    <= '0;
      mem_cke   <= 1'b0;
      ref_cnt   <= '0;
      ref_pend  <= 1'b0;
      init_done <= 1'b0;
      wr_l      <= 1'b0;
      ba_l      <= '0;
      col_l     <= '0;
    end else begin
      state    <= nxt;
      cnt      <= cnt_d;
      cmd_q    <= cmd_d;
      mem_addr <= a_d;
      mem_ba   <= ba_d;
      mem_cke  <= 1'b1;
      if (take) begin
        wr_l  <= req_write;
        ba_l  <= req_bank;
        col_l <= req_col;
      end
      if (init_set) init_done <= 1'b1;
      if (ref_clr) ref_pend <= 1'b0;
      if (init_done) begin
        if (ref_cnt == REF_W'(T_REFI - 1)) begin
          ref_cnt  <= '0;
          ref_pend <= 1'b1;
        end else begin
          ref_cnt <= ref_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int BA_W  = 2,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RC  = 7,
  parameter int T_RFC = 7,
  parameter int T_MRD = 2,
  parameter int T_DAL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [BA_W-1:0] req_bank,
  input logic            mem_cke,
  input logic            mem_cs_n,
  input logic            mem_ras_n,
  input logic            mem_cas_n,
  input logic            mem_we_n,
  input logic            ap_bit,
  input logic [BA_W-1:0] mem_ba
);
  localparam logic [15:0] SAT = 16'hFFFF;
  wire [2:0] code = {mem_ras_n, mem_cas_n, mem_we_n};
  wire issued = !mem_cs_n && (code != 3'b111);
  wire is_act = !mem_cs_n && code == 3'b011;
  wire is_rd  = !mem_cs_n && code == 3'b101;
  wire is_wr  = !mem_cs_n && code == 3'b100;
  wire is_pre = !mem_cs_n && code == 3'b010;
  wire is_ref = !mem_cs_n && code == 3'b001;
  wire is_mrs = !mem_cs_n && code == 3'b000;

  logic [15:0] s_act, s_rd, s_wr, s_pre, s_ref, s_mrs;
  logic        seen_mrs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_act, s_rd, s_wr, s_pre, s_ref, s_mrs} <= {6{SAT}};
      seen_mrs <= 1'b0;
    end else begin
      s_act <= is_act ? 16'd1 : (s_act == SAT ? SAT : s_act + 16'd1);
      s_rd  <= is_rd  ? 16'd1 : (s_rd  == SAT ? SAT : s_rd  + 16'd1);
      s_wr  <= is_wr  ? 16'd1 : (s_wr  == SAT ? SAT : s_wr  + 16'd1);
      s_pre <= is_pre ? 16'd1 : (s_pre == SAT ? SAT : s_pre + 16'd1);
      s_ref <= is_ref ? 16'd1 : (s_ref == SAT ? SAT : s_ref + 16'd1);
      s_mrs <= is_mrs ? 16'd1 : (s_mrs == SAT ? SAT : s_mrs + 16'd1);
      if (is_mrs) seen_mrs <= 1'b1;
    end
  end

  assert_rw_after_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> (s_act == 16'(T_RCD)));
  assert_ap_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr || is_pre) |-> ap_bit);
  assert_ref_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issued |-> (s_ref >= 16'(T_RFC)));
  assert_pre_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issued |-> (s_pre >= 16'(T_RP)));
  assert_mrs_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issued |-> (s_mrs >= 16'(T_MRD)));
  assert_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_ref) |-> (s_wr >= 16'(T_DAL) && s_rd >= 16'(T_RP + 1) && s_act >= 16'(T_RC)));
  assert_ready_to_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (is_act && mem_ba == $past(req_bank)));
  assert_init_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (seen_mrs && s_mrs >= 16'(T_MRD - 1)));
  assert_cke_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issued |-> mem_cke);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .BA_W(BA_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
  .T_RFC(T_RFC), .T_MRD(T_MRD), .T_DAL(T_DAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .req_bank(req_addr[BA_W+ROW_W+COL_W-1 -: BA_W]),
  .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
  .ap_bit(mem_addr[AP_BIT]), .mem_ba(mem_ba)
);

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  localparam int T_INIT = 10, T_RCD = 2, T_RP = 2, T_RC = 6, T_RFC = 7;
  localparam int T_MRD = 2, T_DAL = 5, T_REFI = 300;
  localparam logic [11:0] MODE = 12'h022;
  localparam int WR_GAP = (T_RC - T_RCD > T_DAL) ? T_RC - T_RCD : T_DAL;
  localparam int RD_GAP = (T_RC - T_RCD > T_RP + 1) ? T_RC - T_RCD : T_RP + 1;
  localparam int PRE_AT = T_INIT + 1;
  localparam int MRS_AT = PRE_AT + T_RP + 2 * T_RFC;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 0, rst_n = 0, req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic req_ready, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [11:0] mem_addr;
  logic [1:0] mem_ba;
  int cyc = 0, vectors = 0, miscompares = 0, bad_cycles = 0;
  bit done = 0;
  wire [3:0] cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

  sdram_cmd_seq #(.T_INIT(T_INIT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_DAL(T_DAL), .T_REFI(T_REFI), .MODE_WORD(MODE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_ba(mem_ba));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk)
    if (rst_n && cyc > 0)
      if (!mem_cke || mem_cs_n || cmd[2:0] == 3'b110) bad_cycles++;

  function automatic logic [22:0] mk(input logic [1:0] b, input logic [11:0] r, input logic [8:0] c);
    return {b, r, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_cmd(output logic [3:0] c, output int at);
    do @(negedge clk); while (cmd == C_NOP || mem_cs_n);
    c = cmd; at = cyc;
  endtask

  task automatic drive(input bit wr, input logic [22:0] a);
    req_valid = 1; req_write = wr; req_addr = a;
  endtask

  task automatic finish_access(input bit wr, input logic [22:0] a, input int exp_act, output int rw_at);
    logic [3:0] c;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    chk("R4 activate code", cmd, C_ACT);
    chk("R4 activate cycle", cyc, exp_act);
    chk("R4 activate bank", mem_ba, a[22:21]);
    chk("R4 activate row", mem_addr, a[20:9]);
    next_cmd(c, rw_at);
    chk("R6 column command", c, wr ? C_WR : C_RD);
    chk("R5 column cycle", rw_at, exp_act + T_RCD);
    chk("R5 column address", mem_addr, {3'b010, a[8:0]});
    chk("R5 column bank", mem_ba, a[22:21]);
  endtask

  task automatic t_reset;
    drive(1, mk(2'd2, 12'hABC, 9'h15A));
    repeat (3) @(negedge clk);
    chk("R1 cke low", mem_cke, 0);
    chk("R1 strobes high", cmd, 4'b1111);
    chk("R1 no ready", req_ready, 0);
    rst_n = 1;
  endtask

  task automatic t_init(output int rw_at);
    int pre_at = -1, r1 = -1, r2 = -1, mrs_at = -1, early = 0;
    logic pre_ap = 0; logic [11:0] mrs_a = '0; logic [1:0] mrs_b = '1;
    for (int c = 1; c <= MRS_AT + T_MRD - 1; c++) begin
      @(negedge clk);
      if (c == 1) chk("R9 cke high after reset", mem_cke, 1);
      if (req_ready && cyc < MRS_AT + T_MRD - 1) early++;
      if (!mem_cs_n) case (cmd)
        C_PRE: begin pre_at = cyc; pre_ap = mem_addr[10]; end
        C_REF: if (r1 < 0) r1 = cyc; else r2 = cyc;
        C_MRS: begin mrs_at = cyc; mrs_a = mem_addr; mrs_b = mem_ba; end
        default: ;
      endcase
    end
    chk("R2 precharge cycle", pre_at, PRE_AT);
    chk("R2 precharge all banks", pre_ap, 1);
    chk("R3 first refresh after precharge", r1, PRE_AT + T_RP);
    chk("R3 second refresh", r2, PRE_AT + T_RP + T_RFC);
    chk("R3 mode set cycle", mrs_at, MRS_AT);
    chk("R2 mode word", mrs_a, MODE);
    chk("R2 mode bank", mrs_b, 0);
    chk("R10 no early ready", early, 0);
    chk("R10 ready at first slot", req_ready, 1);
    finish_access(1, req_addr, MRS_AT + T_MRD, rw_at);
  endtask

  task automatic t_back_to_back(input int w0, output int last);
    int rd1, wr2;
    drive(0, mk(2'd0, 12'h001, 9'h1FF));
    finish_access(0, mk(2'd0, 12'h001, 9'h1FF), w0 + WR_GAP, rd1);
    drive(1, mk(2'd3, 12'hFFF, 9'h000));
    finish_access(1, mk(2'd3, 12'hFFF, 9'h000), rd1 + RD_GAP, wr2);
    drive(0, mk(2'd1, 12'h800, 9'h0AA));
    finish_access(0, mk(2'd1, 12'h800, 9'h0AA), wr2 + WR_GAP, last);
  endtask

  task automatic t_refresh_idle(output int r2);
    logic [3:0] c; int r1;
    next_cmd(c, r1);
    chk("R8 idle refresh code", c, C_REF);
    next_cmd(c, r2);
    chk("R8 idle refresh code", c, C_REF);
    chk("R8 refresh interval", r2 - r1, T_REFI);
  endtask

  task automatic t_collision(input int r_prev, output int r_now);
    logic [3:0] c; int rd;
    while (cyc < r_prev + T_REFI - 1) @(negedge clk);
    drive(0, mk(2'd1, 12'h5A5, 9'h033));
    #1 chk("R8 request held behind refresh", req_ready, 0);
    next_cmd(c, r_now);
    chk("R8 refresh first", c, C_REF);
    chk("R8 refresh cycle", r_now, r_prev + T_REFI);
    finish_access(0, mk(2'd1, 12'h5A5, 9'h033), r_now + T_RFC, rd);
  endtask

  task automatic t_deferral(input int r_prev);
    logic [3:0] c; int wr, rf;
    while (cyc < r_prev + T_REFI - 2) @(negedge clk);
    drive(1, mk(2'd3, 12'h3C3, 9'h101));
    finish_access(1, mk(2'd3, 12'h3C3, 9'h101), r_prev + T_REFI - 1, wr);
    next_cmd(c, rf);
    chk("R8 deferred refresh code", c, C_REF);
    chk("R7 refresh after write recovery", rf, wr + WR_GAP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int w0, last, r2, r3;
    t_reset();
    t_init(w0);
    t_back_to_back(w0, last);
    t_refresh_idle(r2);
    t_collision(r2, r3);
    t_deferral(r3);
    chk("R9 only legal commands or no-op", bad_cycles, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule